// File: doc/BRIEF.md
# Transceiver Power-Enable Pin and Companion Clock Controller

This block owns the three power-enable pads of an external radio transceiver: one for the low-frequency section, one for the high-frequency section and one for the receiver. Each pad has a direction bit and a level bit. When the direction bit is clear, the pad is an input. When it is set, the block drives the pad, and the level bit picks between the idle (HIGH) level and the asserted (LOW) level. The power-enable pads are active low.

The low-frequency and high-frequency pads each have a companion clock output. A companion clock runs only while its pad is driven and asserted. At all other times it is held LOW. While running, it follows the master clock or half the master clock, chosen by one select bit shared by both clocks. The full-rate clock is gated by a latch that updates only during the low phase of the master clock. The half-rate clock comes straight from a register, so neither clock can produce a runt pulse.

A readback vector returns the inverse of each pad's level, taken through a synchronizer. The readback works the same way whether the block or an external device drives the pad. Configuration is loaded through a single write strobe. Register decoding and the pad cells are outside the block. Each pad is represented by its output value, its output enable and the level it returns.

Top module: `pwr_pin_ctrl`

## Requirements
- R1: After reset, every direction bit is 1, every level bit is 0 and the select bit is 0. So pad_oe_o = 3'b111, pad_out_o = 3'b111, and both companion clocks stay LOW.
- R2: When cfg_we_i is high at a rising clock edge, the direction, level and select bits load cfg_drive_i, cfg_assert_i and cfg_half_i. When cfg_we_i is low, the settings and the pad outputs keep their values.
- R3: A pad whose direction bit is 0 is not driven (pad_oe_o bit 0), whatever its level bit. If that pad is pin 0 or pin 1, its companion clock stays LOW.
- R4: A pad with direction 1 and level 0 is driven HIGH (pad_oe_o = 1, pad_out_o = 1), and its companion clock stays LOW.
- R5: A pad with direction 1 and level 1 is driven LOW (pad_oe_o = 1, pad_out_o = 0), and its companion clock runs.
- R6: With the select bit 0, a running companion clock makes exactly one rising edge per master clock cycle. It is high only while the master clock is high.
- R7: With the select bit 1, a running companion clock makes exactly one rising edge per two master clock cycles.
- R8: rdbk_o bit i equals the inverse of pad_in_i bit i as it was two rising edges earlier. This holds in both input and output direction.
- R9: Pin index 0 is the low-frequency pad with companion clock comp_clk_o[0]. Index 1 is the high-frequency pad with comp_clk_o[1]. Index 2 is the receive pad, which has no companion clock, so its settings never start either clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the settings |
| cfg_drive_i | input | 3 | Direction bits to load (1 = block drives the pad) |
| cfg_assert_i | input | 3 | Level bits to load (1 = drive LOW, i.e. assert) |
| cfg_half_i | input | 1 | Select bit to load (1 = companion clocks at half rate) |
| pad_in_i | input | 3 | Level seen at each pad |
| pad_out_o | output | 3 | Value driven onto each pad |
| pad_oe_o | output | 3 | Output enable for each pad |
| rdbk_o | output | 3 | Inverted, synchronized pad levels |
| comp_clk_o | output | 2 | Companion clocks: bit 0 low-frequency, bit 1 high-frequency |

## Verification
The hardest behaviour to reach from the ports is the rate and the gating of the companion clocks. Their edges are not aligned to any register the bench can sample. The stimulus loads each combination of direction, level and select bit, waits for the gate to settle, and then counts rising clock edges over a fixed window of master cycles. Readback latency is exercised separately: an external pad driver is modelled with the pads in input direction, and the level is stepped between clock edges.

// File: rtl/pe_pkg.sv
package pe_pkg;
   localparam int unsigned PE_PIN_LF = 0;
   localparam int unsigned PE_PIN_HF = 1;
   localparam int unsigned PE_PIN_RX = 2;

   typedef enum logic [1:0] {
      PE_MODE_INPUT = 2'd0,
      PE_MODE_IDLE  = 2'd1,
      PE_MODE_ON    = 2'd2
   } pe_mode_e;

   function automatic pe_mode_e pe_decode(input logic drive, input logic assrt);
      if (!drive)     return PE_MODE_INPUT;
      else if (assrt) return PE_MODE_ON;
      else            return PE_MODE_IDLE;
   endfunction
endpackage

// File: rtl/pe_cfg_regs.sv
module pe_cfg_regs #(
   parameter int unsigned NUM_PIN = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic [NUM_PIN-1:0] drive_d_i,
   input  logic [NUM_PIN-1:0] assert_d_i,
   input  logic               half_d_i,
   output logic [NUM_PIN-1:0] drive_q_o,
   output logic [NUM_PIN-1:0] assert_q_o,
   output logic               half_q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         drive_q_o  <= '1;
         assert_q_o <= '0;
         half_q_o   <= 1'b0;
      end else if (we_i) begin
         drive_q_o  <= drive_d_i;
         assert_q_o <= assert_d_i;
         half_q_o   <= half_d_i;
      end
   end
endmodule

// File: rtl/pe_pin_sync.sv
module pe_pin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pe_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    chain_q[s] <= RST_VAL;
         else if (s == 0) chain_q[s] <= d_i;
         else            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pe_clk_gate.sv
module pe_clk_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic half_i,
   output logic gclk_o
);
   logic full_en;
   logic full_lat;
   logic full_gclk;
   logic half_q;

   assign full_en = run_i & ~half_i;

   // enable is captured only during the low phase of the source clock
   always_latch begin
      if (!rst_ni)     full_lat = 1'b0;
      else if (!clk_i) full_lat = full_en;
   end

   assign full_gclk = clk_i & full_lat;

   // half-rate clock launched from a register: toggles while enabled,
   // always finishes its high phase and parks LOW when disabled
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     half_q <= 1'b0;
      else if (half_q) half_q <= 1'b0;
      else             half_q <= run_i & half_i;
   end

   assign gclk_o = full_gclk | half_q;
endmodule

// File: rtl/pwr_pin_ctrl.sv
module pwr_pin_ctrl
   import pe_pkg::*;
#(
   parameter int unsigned NUM_PIN     = 3,
   parameter int unsigned NUM_CLK     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cfg_we_i,
   input  logic [NUM_PIN-1:0] cfg_drive_i,
   input  logic [NUM_PIN-1:0] cfg_assert_i,
   input  logic               cfg_half_i,
   input  logic [NUM_PIN-1:0] pad_in_i,
   output logic [NUM_PIN-1:0] pad_out_o,
   output logic [NUM_PIN-1:0] pad_oe_o,
   output logic [NUM_PIN-1:0] rdbk_o,
   output logic [NUM_CLK-1:0] comp_clk_o
);
   if (NUM_CLK == 0 || NUM_CLK > NUM_PIN) begin : g_bad_clk
      $error("pwr_pin_ctrl: NUM_CLK must be in 1..NUM_PIN");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwr_pin_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PIN-1:0] drive_q;
   logic [NUM_PIN-1:0] assert_q;
   logic               half_q;
   logic [NUM_PIN-1:0] pin_on;
   logic [NUM_PIN-1:0] pad_sync;

   pe_cfg_regs #(.NUM_PIN(NUM_PIN)) i_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (cfg_we_i),
      .drive_d_i  (cfg_drive_i),
      .assert_d_i (cfg_assert_i),
      .half_d_i   (cfg_half_i),
      .drive_q_o  (drive_q),
      .assert_q_o (assert_q),
      .half_q_o   (half_q)
   );

   for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      pe_mode_e mode;
      assign mode         = pe_decode(drive_q[p], assert_q[p]);
      assign pad_oe_o[p]  = (mode != PE_MODE_INPUT);
      assign pad_out_o[p] = (mode != PE_MODE_ON);
      assign pin_on[p]    = (mode == PE_MODE_ON);

      pe_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (pad_in_i[p]),
         .q_o    (pad_sync[p])
      );
      assign rdbk_o[p] = ~pad_sync[p];
   end

   for (genvar k = 0; k < NUM_CLK; k++) begin : g_clk
      pe_clk_gate i_gate (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .run_i  (pin_on[k]),
         .half_i (half_q),
         .gclk_o (comp_clk_o[k])
      );
   end
endmodule

// File: rtl/pwr_pin_ctrl_chk.sv
module pwr_pin_ctrl_chk #(
   parameter int unsigned NUM_PIN     = 3,
   parameter int unsigned NUM_CLK     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               cfg_we_i,
   input logic [NUM_PIN-1:0] cfg_drive_i,
   input logic [NUM_PIN-1:0] cfg_assert_i,
   input logic [NUM_PIN-1:0] pad_in_i,
   input logic [NUM_PIN-1:0] pad_out_o,
   input logic [NUM_PIN-1:0] pad_oe_o,
   input logic [NUM_PIN-1:0] rdbk_o,
   input logic [NUM_CLK-1:0] comp_clk_o,
   input logic               half_q
);
   logic [3:0] since_rst;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         since_rst <= '0;
      else if (since_rst < 4'(SYNC_STAGES)) since_rst <= since_rst + 4'd1;
   end

   p_write_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_i |=> pad_oe_o == $past(cfg_drive_i));
   p_write_lvl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_i |=> pad_out_o == ($past(cfg_drive_i) & ~$past(cfg_assert_i)) | ~$past(cfg_drive_i));
   p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_we_i |=> $stable(pad_oe_o) && $stable(pad_out_o));
   p_rdbk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst == 4'(SYNC_STAGES)) |-> rdbk_o == ~$past(pad_in_i, SYNC_STAGES));

   for (genvar k = 0; k < NUM_CLK; k++) begin : g_k
      logic on_k;
      assign on_k = pad_oe_o[k] & ~pad_out_o[k];

      p_quiet_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
         (!on_k && $past(!on_k)) |-> !comp_clk_o[k]);
      p_full_rate_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
         (on_k && $past(on_k) && !half_q && $past(!half_q)) |-> comp_clk_o[k]);
      p_half_rate_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
         (on_k && $past(on_k) && $past(on_k, 2) && half_q && $past(half_q) && $past(half_q, 2))
         |-> comp_clk_o[k] != $past(comp_clk_o[k]));
   end
endmodule

bind pwr_pin_ctrl pwr_pin_ctrl_chk #(
   .NUM_PIN(NUM_PIN), .NUM_CLK(NUM_CLK), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .cfg_we_i     (cfg_we_i),
   .cfg_drive_i  (cfg_drive_i),
   .cfg_assert_i (cfg_assert_i),
   .pad_in_i     (pad_in_i),
   .pad_out_o    (pad_out_o),
   .pad_oe_o     (pad_oe_o),
   .rdbk_o       (rdbk_o),
   .comp_clk_o   (comp_clk_o),
   .half_q       (half_q)
);

// File: tb/test_pwr_pin_ctrl.sv
module test_pwr_pin_ctrl;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WIN        = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [2:0] drive = 3'b111;
   logic [2:0] assrt = 3'b000;
   logic       half = 1'b0;
   logic [2:0] ext_lvl = 3'b000;
   logic [2:0] pad_in;
   logic [2:0] pad_out;
   logic [2:0] pad_oe;
   logic [2:0] rdbk;
   logic [1:0] comp_clk;

   int checks = 0;
   int errors = 0;
   int lf_edges = 0;
   int hf_edges = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // pad model: driven value when enabled, external level otherwise
   for (genvar i = 0; i < 3; i++) begin : g_pad
      assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext_lvl[i];
   end

   always @(posedge comp_clk[0]) lf_edges++;
   always @(posedge comp_clk[1]) hf_edges++;

   pwr_pin_ctrl i_pwr_pin_ctrl (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cfg_we_i     (we),
      .cfg_drive_i  (drive),
      .cfg_assert_i (assrt),
      .cfg_half_i   (half),
      .pad_in_i     (pad_in),
      .pad_out_o    (pad_out),
      .pad_oe_o     (pad_oe),
      .rdbk_o       (rdbk),
      .comp_clk_o   (comp_clk)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [2:0] d, input logic [2:0] a, input logic h);
      @(negedge clk);
      drive = d; assrt = a; half = h; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic count_edges(output int c0, output int c1);
      int s0, s1;
      repeat (3) @(negedge clk);
      s0 = lf_edges; s1 = hf_edges;
      repeat (WIN) @(negedge clk);
      c0 = lf_edges - s0; c1 = hf_edges - s1;
   endtask

   task automatic t_reset;
      int c0, c1;
      @(negedge clk);
      check("R1 oe", 32'(pad_oe), 32'h7);
      check("R1 out", 32'(pad_out), 32'h7);
      count_edges(c0, c1);
      check("R1 lf clk quiet", c0, 0);
      check("R1 hf clk quiet", c1, 0);
      check("R8 rdbk driven high", 32'(rdbk), 32'h0);
   endtask

   task automatic t_write_ignored;
      @(negedge clk);
      drive = 3'b000; assrt = 3'b111; half = 1'b1; we = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 oe without strobe", 32'(pad_oe), 32'h7);
      check("R2 out without strobe", 32'(pad_out), 32'h7);
      check("R2 clk without strobe", 32'(comp_clk), 32'h0);
   endtask

   task automatic t_input_mode;
      int c0, c1;
      ext_lvl = 3'b101;
      write_cfg(3'b000, 3'b111, 1'b0);
      check("R3 oe off", 32'(pad_oe), 32'h0);
      count_edges(c0, c1);
      check("R3 lf clk quiet in input", c0, 0);
      check("R3 hf clk quiet in input", c1, 0);
      check("R8 rdbk input", 32'(rdbk), 32'h2);
      // latency: level stepped between edges
      ext_lvl = 3'b010;
      @(negedge clk);
      check("R8 rdbk after one edge", 32'(rdbk), 32'h2);
      @(negedge clk);
      check("R8 rdbk after two edges", 32'(rdbk), 32'h5);
   endtask

   task automatic t_idle_high;
      int c0, c1;
      write_cfg(3'b111, 3'b000, 1'b1);
      check("R4 oe", 32'(pad_oe), 32'h7);
      check("R4 out high", 32'(pad_out), 32'h7);
      count_edges(c0, c1);
      check("R4 lf quiet", c0, 0);
      check("R4 hf quiet", c1, 0);
   endtask

   task automatic t_full_rate;
      int c0, c1;
      write_cfg(3'b111, 3'b011, 1'b0);
      check("R5 out low", 32'(pad_out), 32'h4);
      check("R5 oe", 32'(pad_oe), 32'h7);
      count_edges(c0, c1);
      check("R6 lf full rate", c0, WIN);
      check("R6 hf full rate", c1, WIN);
      check("R8 rdbk output low", 32'(rdbk), 32'h3);
   endtask

   task automatic t_half_rate;
      int c0, c1;
      write_cfg(3'b111, 3'b011, 1'b1);
      count_edges(c0, c1);
      check("R7 lf half rate", c0, WIN/2);
      check("R7 hf half rate", c1, WIN/2);
   endtask

   task automatic t_mixed;
      int c0, c1;
      ext_lvl = 3'b000;
      write_cfg(3'b101, 3'b011, 1'b0);
      check("R3 hf input oe", 32'(pad_oe), 32'h5);
      count_edges(c0, c1);
      check("R5 lf runs alone", c0, WIN);
      check("R3 hf input quiet", c1, 0);
   endtask

   task automatic t_rx_only;
      int c0, c1;
      write_cfg(3'b111, 3'b100, 1'b0);
      check("R9 rx out low", 32'(pad_out), 32'h3);
      count_edges(c0, c1);
      check("R9 lf unaffected", c0, 0);
      check("R9 hf unaffected", c1, 0);
      check("R9 rdbk rx asserted", 32'(rdbk), 32'h4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_ignored();
      t_input_mode();
      t_idle_high();
      t_full_rate();
      t_half_rate();
      t_mixed();
      t_rx_only();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule